// File: doc/BRIEF.md
# BCD Calendar Clock Counter

This block keeps the time of day and the calendar date as packed BCD fields: seconds, minutes, hours, weekday, day of month, month and a two-digit year. A one-cycle pulse on `tick_i` marks each elapsed second. When the clock is running, each pulse advances the seconds field. Carries ripple through the calendar, and the month lengths and leap years are taken into account.

A host reaches every field through a byte-wide port with a 3-bit field address. A write is registered at the clock edge. A read is combinational from the stored state. Every write is decoded from its own bit slice and range-checked. A write whose value is not valid BCD, or lies outside the field's range, leaves the field unchanged. Bit 7 of the seconds register is a run/stop control, and bit 6 of the weekday register holds a century flag that software sets and clears. The parameter `YEAR_BASE` is the calendar year that year register value 00 stands for, and the leap-year rule is applied to it.

Top module: `bcd_rtc`

## Requirements
- R1: While `rst` is high at a clock edge, the state becomes 00:00:00 with weekday 1, day 01, month 01, year 00, the stop bit clear and the century flag clear.
- R2: Field addresses are 0 = seconds, 1 = minutes, 2 = hours, 3 = weekday, 4 = day of month, 5 = month, 6 = year. Address 7 reads as 0x00, and a write to address 7 changes nothing.
- R3: A seconds write always stores bit 7 as the stop bit. Bits [6:0] are stored only when they are valid BCD from 00 to 59. Reading address 0 returns the stop bit in bit 7 and the seconds in bits [6:0].
- R4: A minutes write takes bits [6:0] and accepts BCD 00 to 59. An hours write takes bits [5:0] and accepts BCD 00 to 23. A rejected value leaves the field unchanged.
- R5: A weekday write always stores bit 6 as the century flag. Bits [2:0] are stored only when they are 1 to 7. Reading address 3 returns the century flag in bit 6, the weekday in bits [2:0], and zero in all other bits.
- R6: A day-of-month write takes bits [5:0] and accepts BCD 01 to 31. A month write takes bits [4:0] and accepts BCD 01 to 12. A year write takes all 8 bits and accepts BCD 00 to 99.
- R7: A `tick_i` pulse while running, with no write in the same cycle, adds one to the seconds in BCD (09 becomes 10). At 59 the seconds return to 00 and the minutes advance. Minutes carry into hours the same way, and hours carry from 23 to 00.
- R8: When the hours carry, the weekday steps (7 becomes 1) and the day advances. When the day carries, it becomes 01 and the month advances. December carries to January and the year advances, and year 99 becomes 00.
- R9: The day carries when it has reached the month length: 30 days for months 04, 06, 09 and 11; 29 days for month 02 when YEAR_BASE plus the year value is divisible by 4, otherwise 28; 31 days for all other months. A stored day beyond the month length becomes 01 at the next day carry.
- R10: While the stop bit is set, ticks are ignored and all time fields are held. Clearing the stop bit resumes counting from the held value.
- R11: A tick that arrives in the same cycle as any write is discarded.
- R12: `rdata_o` shows the value written to a field in the cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | One-cycle pulse per elapsed second |
| we_i | input | 1 | Write strobe for the addressed field |
| addr_i | input | 3 | Field address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data of the addressed field (combinational) |

## Verification
The assertions assume that `tick_i` is a single-cycle pulse and that fields change only through the write port or a tick. They also assume the stored weekday is never zero, which holds because reset loads 1 and a write of 0 is rejected. The stimulus keeps to these assumptions. The bench drives every input on the falling edge and raises the tick for exactly one cycle. It writes invalid values only through the port, where the range check must reject them. It places ticks after setup writes, except in the one test that deliberately combines a write and a tick in the same cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NF = 6;   // chained BCD fields
    localparam int FS = 0;   // seconds
    localparam int FM = 1;   // minutes
    localparam int FH = 2;   // hours
    localparam int FD = 3;   // day of month
    localparam int FN = 4;   // month
    localparam int FY = 5;   // year

    typedef struct packed {
        logic                  stop;
        logic                  cent;
        logic [2:0]            wday;
        logic [NF-1:0][7:0]    fld;
    } rtc_state_t;

    function automatic logic bcd_in_range(logic [7:0] v, logic [7:0] lo, logic [7:0] hi);
        return (v[3:0] <= 4'd9) && (v[7:4] <= 4'd9) && (v >= lo) && (v <= hi);
    endfunction

    function automatic logic [6:0] bcd2bin(logic [7:0] v);
        return 7'(v[7:4]) * 7'd10 + 7'(v[3:0]);
    endfunction

    function automatic logic [7:0] bcd_inc(logic [7:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step
    import rtc_pkg::*;
(
    input  logic       en_i,
    input  logic [7:0] val_i,
    input  logic [7:0] lo_i,
    input  logic [7:0] hi_i,
    output logic [7:0] nxt_o,
    output logic       wrap_o
);
    always_comb begin
        wrap_o = en_i && (val_i >= hi_i);
        if (!en_i)
            nxt_o = val_i;
        else if (wrap_o)
            nxt_o = lo_i;
        else
            nxt_o = bcd_inc(val_i);
    end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len
    import rtc_pkg::*;
#(
    parameter int YEAR_BASE = 2000
) (
    input  logic [7:0] month_i,
    input  logic [7:0] year_i,
    output logic [7:0] len_o
);
    logic [31:0] full_year;
    logic        leap;

    always_comb begin
        full_year = 32'(YEAR_BASE) + 32'(bcd2bin(year_i));
        leap      = (full_year[1:0] == 2'b00);
        case (month_i)
            8'h02:                      len_o = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: len_o = 8'h30;
            default:                    len_o = 8'h31;
        endcase
    end
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
    import rtc_pkg::*;
#(
    parameter int YEAR_BASE = 2000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       we_i,
    input  logic [2:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o
);
    rtc_state_t            state_d, state_q;
    logic [NF-1:0][7:0]    lo, hi, nxt;
    logic [NF-1:0]         en, wrap;
    logic [7:0]            mlen;
    logic                  run;

    assign run = tick_i && !we_i && !state_q.stop;

    rtc_month_len #(.YEAR_BASE(YEAR_BASE)) mlen_i (
        .month_i (state_q.fld[FN]),
        .year_i  (state_q.fld[FY]),
        .len_o   (mlen)
    );

    always_comb begin
        lo = '0;
        hi = '0;
        hi[FS] = 8'h59;
        hi[FM] = 8'h59;
        hi[FH] = 8'h23;
        lo[FD] = 8'h01;
        hi[FD] = mlen;
        lo[FN] = 8'h01;
        hi[FN] = 8'h12;
        hi[FY] = 8'h99;
    end

    for (genvar i = 0; i < NF; i++) begin : g_chain
        if (i == 0) begin : g_first
            assign en[i] = run;
        end else begin : g_next
            assign en[i] = wrap[i-1];
        end
        rtc_bcd_step step_i (
            .en_i   (en[i]),
            .val_i  (state_q.fld[i]),
            .lo_i   (lo[i]),
            .hi_i   (hi[i]),
            .nxt_o  (nxt[i]),
            .wrap_o (wrap[i])
        );
    end

    always_comb begin
        state_d = state_q;
        if (we_i) begin
            case (addr_i)
                3'd0: begin
                    state_d.stop = wdata_i[7];
                    if (bcd_in_range({1'b0, wdata_i[6:0]}, 8'h00, 8'h59))
                        state_d.fld[FS] = {1'b0, wdata_i[6:0]};
                end
                3'd1: if (bcd_in_range({1'b0, wdata_i[6:0]}, 8'h00, 8'h59))
                          state_d.fld[FM] = {1'b0, wdata_i[6:0]};
                3'd2: if (bcd_in_range({2'b0, wdata_i[5:0]}, 8'h00, 8'h23))
                          state_d.fld[FH] = {2'b0, wdata_i[5:0]};
                3'd3: begin
                    state_d.cent = wdata_i[6];
                    if (wdata_i[2:0] != 3'd0)
                        state_d.wday = wdata_i[2:0];
                end
                3'd4: if (bcd_in_range({2'b0, wdata_i[5:0]}, 8'h01, 8'h31))
                          state_d.fld[FD] = {2'b0, wdata_i[5:0]};
                3'd5: if (bcd_in_range({3'b0, wdata_i[4:0]}, 8'h01, 8'h12))
                          state_d.fld[FN] = {3'b0, wdata_i[4:0]};
                3'd6: if (bcd_in_range(wdata_i, 8'h00, 8'h99))
                          state_d.fld[FY] = wdata_i;
                default: ;
            endcase
        end else if (run) begin
            state_d.fld = nxt;
            if (wrap[FH])
                state_d.wday = (state_q.wday == 3'd7) ? 3'd1 : state_q.wday + 3'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= '0;
            state_q.wday <= 3'd1;
            state_q.fld[FD] <= 8'h01;
            state_q.fld[FN] <= 8'h01;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        case (addr_i)
            3'd0:    rdata_o = {state_q.stop, state_q.fld[FS][6:0]};
            3'd1:    rdata_o = state_q.fld[FM];
            3'd2:    rdata_o = state_q.fld[FH];
            3'd3:    rdata_o = {1'b0, state_q.cent, 3'b000, state_q.wday};
            3'd4:    rdata_o = state_q.fld[FD];
            3'd5:    rdata_o = state_q.fld[FN];
            3'd6:    rdata_o = state_q.fld[FY];
            default: rdata_o = 8'h00;
        endcase
    end
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk
    import rtc_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       tick_i,
    input logic       we_i,
    input logic [2:0] addr_i,
    input rtc_state_t state_q,
    input logic       yr_wrap
);
    AST_SEC_VALID: assert property (@(posedge clk) disable iff (rst)
        bcd_in_range(state_q.fld[FS], 8'h00, 8'h59));                                       // R3
    AST_MONTH_VALID: assert property (@(posedge clk) disable iff (rst)
        bcd_in_range(state_q.fld[FN], 8'h01, 8'h12));                                       // R6
    AST_WDAY_NONZERO: assert property (@(posedge clk) disable iff (rst)
        state_q.wday != 3'd0);                                                              // R5
    AST_SEC_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !we_i && !state_q.stop && state_q.fld[FS] != 8'h59)
        |=> (state_q.fld[FS] != $past(state_q.fld[FS])));                                   // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !we_i) |=> $stable(state_q));                                           // R7
    AST_YEAR_WRAP: assert property (@(posedge clk) disable iff (rst)
        yr_wrap |=> (state_q.fld[FY] == 8'h00));                                            // R8
    AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (state_q.stop && !we_i) |=> $stable(state_q.fld));                                  // R10
    AST_WRITE_DROPS_TICK: assert property (@(posedge clk) disable iff (rst)
        (we_i && tick_i && addr_i != 3'd0) |=> $stable(state_q.fld[FS]));                   // R11
endmodule

bind bcd_rtc rtc_chk chk_i (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .state_q (state_q),
    .yr_wrap (wrap[rtc_pkg::FY])
);

// File: tb/bcd_rtc_tb.sv
module bcd_rtc_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       we_i = 1'b0;
    logic [2:0] addr_i = 3'd0;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] rdata_o;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    bcd_rtc #(.YEAR_BASE(2000)) dut_i (
        .clk(clk), .rst(rst), .tick_i(tick_i), .we_i(we_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
    );

    // {req, addr, write data, expected readback of the same address}
    localparam int NV = 26;
    localparam logic [31:0] VEC [NV] = '{
        {8'd3, 8'd0, 8'h45, 8'h45},  // R3 valid seconds
        {8'd3, 8'd0, 8'h60, 8'h45},  // R3 out of range
        {8'd3, 8'd0, 8'h5A, 8'h45},  // R3 bad BCD digit
        {8'd3, 8'd0, 8'hC5, 8'hC5},  // R3 stop plus seconds
        {8'd3, 8'd0, 8'h05, 8'h05},  // R3 stop cleared
        {8'd3, 8'd0, 8'hE0, 8'h85},  // R3 stop kept, seconds rejected
        {8'd3, 8'd0, 8'h05, 8'h05},  // R3
        {8'd4, 8'd1, 8'h59, 8'h59},  // R4 minutes
        {8'd4, 8'd1, 8'h60, 8'h59},  // R4
        {8'd4, 8'd2, 8'h23, 8'h23},  // R4 hours
        {8'd4, 8'd2, 8'h24, 8'h23},  // R4
        {8'd4, 8'd2, 8'hE1, 8'h21},  // R4 upper bits masked
        {8'd5, 8'd3, 8'h45, 8'h45},  // R5 century plus weekday
        {8'd5, 8'd3, 8'h00, 8'h05},  // R5 weekday 0 rejected
        {8'd5, 8'd3, 8'h07, 8'h07},  // R5
        {8'd6, 8'd4, 8'h31, 8'h31},  // R6 day
        {8'd6, 8'd4, 8'h32, 8'h31},  // R6
        {8'd6, 8'd4, 8'h00, 8'h31},  // R6
        {8'd6, 8'd5, 8'h12, 8'h12},  // R6 month
        {8'd6, 8'd5, 8'h13, 8'h12},  // R6
        {8'd6, 8'd5, 8'h00, 8'h12},  // R6
        {8'd6, 8'd6, 8'h99, 8'h99},  // R6 year
        {8'd6, 8'd6, 8'h9A, 8'h99},  // R6
        {8'd2, 8'd7, 8'hAA, 8'h00},  // R2 unused address
        {8'd6, 8'd6, 8'h00, 8'h00},  // R6
        {8'd6, 8'd6, 8'h00, 8'h00}   // R6
    };

    task automatic check(input string req, input logic [2:0] a, input logic [7:0] exp);
        addr_i = a;
        #1;
        total++;
        if (rdata_o !== exp) begin
            bad++;
            $display("FAIL %s addr=%0d actual=%02h expected=%02h", req, a, rdata_o, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        we_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk);
        we_i = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        tick_i = 1'b1;
        @(negedge clk);
        tick_i = 1'b0;
    endtask

    task automatic set_eod(input logic [7:0] wd, input logic [7:0] d,
                           input logic [7:0] m, input logic [7:0] y);
        wr(3'd5, m); wr(3'd4, d); wr(3'd6, y); wr(3'd3, wd);
        wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", 3'd0, 8'h00); check("R1", 3'd1, 8'h00); check("R1", 3'd2, 8'h00);
        check("R1", 3'd3, 8'h01); check("R1", 3'd4, 8'h01); check("R1", 3'd5, 8'h01);
        check("R1", 3'd6, 8'h00);

        for (int i = 0; i < NV; i++) begin
            wr(VEC[i][23:16], VEC[i][15:8]);
            check($sformatf("R%0d", VEC[i][31:24]), VEC[i][18:16], VEC[i][7:0]);
        end
        // R2 address 7 write left other fields intact
        check("R2", 3'd1, 8'h59);

        // R8 day carry from Feb 28 in a non-leap year, weekday 7 -> 1
        set_eod(8'h07, 8'h28, 8'h02, 8'h01);
        tick();
        check("R8", 3'd0, 8'h00); check("R8", 3'd1, 8'h00); check("R8", 3'd2, 8'h00);
        check("R8", 3'd3, 8'h01); check("R9", 3'd4, 8'h01); check("R9", 3'd5, 8'h03);
        check("R8", 3'd6, 8'h01);

        // R9 leap year: Feb 28 -> 29 -> Mar 1
        set_eod(8'h02, 8'h28, 8'h02, 8'h04);
        tick();
        check("R9", 3'd4, 8'h29); check("R9", 3'd5, 8'h02);
        wr(3'd2, 8'h23); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        tick();
        check("R9", 3'd4, 8'h01); check("R9", 3'd5, 8'h03);

        // R8 year end 99 -> 00
        set_eod(8'h03, 8'h31, 8'h12, 8'h99);
        tick();
        check("R8", 3'd6, 8'h00); check("R8", 3'd5, 8'h01); check("R8", 3'd4, 8'h01);
        check("R8", 3'd3, 8'h04);

        // R9 day beyond a 30-day month
        set_eod(8'h01, 8'h31, 8'h04, 8'h05);
        tick();
        check("R9", 3'd4, 8'h01); check("R9", 3'd5, 8'h05);

        // R7 BCD digit carry
        wr(3'd1, 8'h09); wr(3'd0, 8'h09);
        tick();
        check("R7", 3'd0, 8'h10); check("R7", 3'd1, 8'h09);
        wr(3'd0, 8'h59);
        tick();
        check("R7", 3'd0, 8'h00); check("R7", 3'd1, 8'h10);

        // R10 stop holds time, clearing resumes
        wr(3'd0, 8'hA0);
        tick(); tick(); tick();
        check("R10", 3'd0, 8'hA0); check("R10", 3'd1, 8'h10);
        wr(3'd0, 8'h20);
        tick();
        check("R10", 3'd0, 8'h21);

        // R11 tick coinciding with a write is dropped
        @(negedge clk);
        we_i = 1'b1; addr_i = 3'd1; wdata_i = 8'h33; tick_i = 1'b1;
        @(negedge clk);
        we_i = 1'b0; tick_i = 1'b0;
        check("R11", 3'd0, 8'h21); check("R11", 3'd1, 8'h33);

        // R12 write visible in the next cycle
        @(negedge clk);
        we_i = 1'b1; addr_i = 3'd1; wdata_i = 8'h17;
        @(negedge clk);
        we_i = 1'b0;
        check("R12", 3'd1, 8'h17);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule